// File: doc/BRIEF.md
# Pin Port with Hardware Blink

A 32-pin general-purpose I/O port controlled through a small 32-bit register bus. Each pin has four control bits: an output level, a direction, a blink enable and an input-sense inversion. The pad side gets an output value and an output enable for every pin. It also returns the raw pad levels, which pass through a two-stage synchronizer before software can see them.

A free-running prescaler makes one square wave that all pins share. On an output pin whose blink bit is set, this wave replaces the stored level, so an LED can flash with no software activity. Software reads each pin's logical level at the data offset. For an input pin this is the synchronized pad level, inverted where the inversion bit is set. For an output pin it is the stored level. Every control register reads back exactly as it was written, so read-modify-write updates of single bits are safe.

The bus has no wait states. A write takes effect at the clock edge where the write strobe is high. A read strobe loads the read-data register at its edge, and the data holds there until the next read.

Top module: `gpio_blink_port`

## Requirements
- R1: After reset, the direction register reads 0xFFFFFFFF (every pin is an input), the level, blink and inversion registers read 0, every pad_oe bit is 0, and bus_rdata is 0.
- R2: A direction bit of 1 makes the pin an input with pad_oe low. A direction bit of 0 makes it an output with pad_oe high. pad_oe changes only in the cycle after a write to offset 0x04.
- R3: The control registers sit at byte offsets 0x00 (output level), 0x04 (direction), 0x08 (blink enable) and 0x0C (input inversion), and each reads back exactly as last written. Read data appears on bus_rdata in the cycle after the edge that samples bus_rd, and it holds until the next read.
- R4: On an output pin whose blink bit is 0, pad_out equals that pin's output-level bit.
- R5: On a pin whose blink bit is 1, pad_out follows one shared square wave. The wave is low out of reset, toggles every BLINK_HALF clock cycles, and is in the same phase on every blinking pin.
- R6: A read of offset 0x10 returns, for each input pin, the synchronized pad level XOR that pin's inversion bit. An inversion bit of 1 gives active-low sensing.
- R7: A read of offset 0x10 returns, for each output pin, its output-level bit.
- R8: A pad change that is first sampled at clock edge k appears in a read of offset 0x10 strobed at edge k+2. A read strobed at edge k still returns the old level.
- R9: Writes to offset 0x10, or to any offset not listed in R3, change no register. Reads of offsets other than 0x00 to 0x10 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pad levels (asynchronous) |
| pad_out | output | 32 | Level driven toward each pad |
| pad_oe | output | 32 | Per-pin driver enable |

## Verification
The assertions assume that the bus never raises bus_wr and bus_rd in the same cycle. They also assume that reset is held for at least two cycles, so the history seen after release is clean. The stimulus issues each access as a single strobe with an idle cycle after it, and holds reset for three cycles. pad_in changes only between clock edges, just after an edge, so the synchronizer timing that the model expects is exact.

// File: rtl/gpio_blink_pkg.sv
package gpio_blink_pkg;

    localparam int PINS   = 32;
    localparam int ADDR_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        OFS_LEVEL  = 5'h00,
        OFS_DIR    = 5'h04,
        OFS_BLINK  = 5'h08,
        OFS_INVERT = 5'h0C,
        OFS_SENSE  = 5'h10
    } reg_ofs_e;

    typedef struct packed {
        logic [PINS-1:0] level;
        logic [PINS-1:0] dir;
        logic [PINS-1:0] blink;
        logic [PINS-1:0] invert;
    } port_ctl_t;

    localparam port_ctl_t CTL_RESET = '{
        level:  '0,
        dir:    '1,
        blink:  '0,
        invert: '0
    };

    // Logical pin value: inputs sense the pad (optionally inverted),
    // outputs report their stored level.
    function automatic logic [PINS-1:0] logical_value(
        input logic [PINS-1:0] dir,
        input logic [PINS-1:0] level,
        input logic [PINS-1:0] invert,
        input logic [PINS-1:0] sensed
    );
        return (dir & (sensed ^ invert)) | (~dir & level);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
    parameter int HALF = 64
) (
    input  logic clk,
    input  logic rst,
    output logic phase
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_blink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [PINS-1:0]   wdata,
    input  logic              rd,
    input  logic [PINS-1:0]   sensed,
    output port_ctl_t         ctl,
    output logic [PINS-1:0]   rdata
);
    port_ctl_t       ctl_q;
    logic [PINS-1:0] rdata_q;
    logic [PINS-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RESET;
        end else if (wr) begin
            case (addr)
                OFS_LEVEL:  ctl_q.level  <= wdata;
                OFS_DIR:    ctl_q.dir    <= wdata;
                OFS_BLINK:  ctl_q.blink  <= wdata;
                OFS_INVERT: ctl_q.invert <= wdata;
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            OFS_LEVEL:  rd_mux = ctl_q.level;
            OFS_DIR:    rd_mux = ctl_q.dir;
            OFS_BLINK:  rd_mux = ctl_q.blink;
            OFS_INVERT: rd_mux = ctl_q.invert;
            OFS_SENSE:  rd_mux = logical_value(ctl_q.dir, ctl_q.level,
                                               ctl_q.invert, sensed);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata_q <= '0;
        else if (rd) rdata_q <= rd_mux;
    end

    assign ctl   = ctl_q;
    assign rdata = rdata_q;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_blink_pkg::*;
(
    input  port_ctl_t       ctl,
    input  logic            phase,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe
);
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        assign pad_out[p] = ctl.blink[p] ? phase : ctl.level[p];
        assign pad_oe[p]  = ~ctl.dir[p];
    end
endmodule

// File: rtl/gpio_blink_port.sv
module gpio_blink_port
    import gpio_blink_pkg::*;
#(
    parameter int BLINK_HALF  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PINS-1:0]   bus_wdata,
    input  logic              bus_rd,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe
);
    port_ctl_t       ctl_q;
    logic [PINS-1:0] sensed;
    logic            blink_phase;

    gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (sensed)
    );

    gpio_blink_gen #(.HALF(BLINK_HALF)) u_blink (
        .clk   (clk),
        .rst   (rst),
        .phase (blink_phase)
    );

    gpio_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .wdata  (bus_wdata),
        .rd     (bus_rd),
        .sensed (sensed),
        .ctl    (ctl_q),
        .rdata  (bus_rdata)
    );

    gpio_pad_mux u_mux (
        .ctl     (ctl_q),
        .phase   (blink_phase),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );
endmodule

// File: rtl/gpio_blink_port_chk.sv
module gpio_blink_port_chk
    import gpio_blink_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [PINS-1:0]   bus_rdata,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe,
    input port_ctl_t         ctl
);
    logic [PINS-1:0] blink_seen;
    assign blink_seen = pad_out & ctl.blink;

    // R1: right after reset release every pin is an input
    a_r1_reset_inputs: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && ctl.level == '0 && ctl.blink == '0))
        else $error("R1 reset state wrong");

    // R2: driver enables move only after a direction write
    a_r2_oe_needs_dir_write: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == OFS_DIR) |=> $stable(pad_oe))
        else $error("R2 pad_oe changed without direction write");

    // R3: read data holds between reads
    a_r3_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata))
        else $error("R3 read data moved without a read");

    // R5: all blinking pins share one phase
    a_r5_shared_phase: assert property (@(posedge clk) disable iff (rst)
        (blink_seen == '0) || (blink_seen == ctl.blink))
        else $error("R5 blinking pins out of phase");

    // R9: data offset write leaves control state untouched
    a_r9_sense_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_SENSE) |=> $stable(ctl))
        else $error("R9 write to data offset changed state");
endmodule

bind gpio_blink_port gpio_blink_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .ctl       (ctl_q)
);

// File: tb/gpio_blink_port_tb.sv
module gpio_blink_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_blink_port #(.BLINK_HALF(HALF)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Behavioural reference
    logic [31:0] m_level, m_dir, m_blink, m_inv, m_rdata;
    logic [31:0] m_pipe [$];
    int          m_tick;
    logic        m_wave;

    initial begin
        m_pipe.push_back('0);
        m_pipe.push_back('0);
    end

    always @(posedge clk) begin
        if (rst) begin
            m_level = '0; m_dir = '1; m_blink = '0; m_inv = '0; m_rdata = '0;
            m_tick = 0; m_wave = 1'b0;
            m_pipe[0] = '0; m_pipe[1] = '0;
        end else begin
            if (bus_rd) begin
                if (bus_addr == 5'h00)      m_rdata = m_level;
                else if (bus_addr == 5'h04) m_rdata = m_dir;
                else if (bus_addr == 5'h08) m_rdata = m_blink;
                else if (bus_addr == 5'h0C) m_rdata = m_inv;
                else if (bus_addr == 5'h10)
                    m_rdata = (m_dir & (m_pipe[0] ^ m_inv)) | (~m_dir & m_level);
                else m_rdata = '0;
            end
            if (bus_wr) begin
                if (bus_addr == 5'h00)      m_level = bus_wdata;
                else if (bus_addr == 5'h04) m_dir   = bus_wdata;
                else if (bus_addr == 5'h08) m_blink = bus_wdata;
                else if (bus_addr == 5'h0C) m_inv   = bus_wdata;
            end
            void'(m_pipe.pop_front());
            m_pipe.push_back(pad_in);
            m_tick++;
            if (m_tick == HALF) begin
                m_tick = 0;
                m_wave = ~m_wave;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        chk("R2 pad_oe", pad_oe, ~m_dir);
        chk("R4/R5 pad_out", pad_out, (m_blink & {32{m_wave}}) | (~m_blink & m_level));
        chk("R3 bus_rdata", bus_rdata, m_rdata);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
        step();
    endtask

    task automatic rd(input logic [4:0] a);
        bus_addr = a; bus_rd = 1'b1;
        step();
        bus_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: all requirements got=hung exp=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int toggles;
        logic prev;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset values
        chk("R1 pad_oe", pad_oe, 32'h0);
        rd(5'h00); chk("R1 level", bus_rdata, 32'h0);
        rd(5'h04); chk("R1 dir", bus_rdata, 32'hFFFF_FFFF);
        rd(5'h08); chk("R1 blink", bus_rdata, 32'h0);
        rd(5'h0C); chk("R1 invert", bus_rdata, 32'h0);

        // R3 readback
        wr(5'h0C, 32'h1234_5678); rd(5'h0C); chk("R3 invert", bus_rdata, 32'h1234_5678);
        wr(5'h00, 32'hC3C3_5A5A); rd(5'h00); chk("R3 level", bus_rdata, 32'hC3C3_5A5A);
        wr(5'h08, 32'h8001_0000); rd(5'h08); chk("R3 blink", bus_rdata, 32'h8001_0000);
        wr(5'h08, 32'h0);
        wr(5'h04, 32'hFFFF_0000); rd(5'h04); chk("R3 dir", bus_rdata, 32'hFFFF_0000);

        // R2, R4
        chk("R2 oe low half", pad_oe, 32'h0000_FFFF);
        chk("R4 level on outputs", pad_out & 32'h0000_FFFF, 32'h0000_5A5A);

        // R6, R7
        pad_in = 32'hF0F0_AAAA;
        repeat (3) step();
        rd(5'h10); chk("R6/R7 sense", bus_rdata, 32'hE2C4_5A5A);

        // R8 synchronizer latency
        pad_in = 32'h0F0F_0000;
        rd(5'h10); chk("R8 old level", bus_rdata, 32'hE2C4_5A5A);
        step();
        rd(5'h10); chk("R8 new level", bus_rdata, 32'h1D3B_5A5A);

        // R6 active low
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h10); chk("R6 inverted", bus_rdata, 32'hF0F0_5A5A);

        // R5 blink
        wr(5'h08, 32'h0001_00FF);
        prev = pad_out[0];
        toggles = 0;
        for (int i = 0; i < 4 * HALF; i++) begin
            step();
            if (pad_out[0] !== prev) toggles++;
            prev = pad_out[0];
            chk("R5 same phase", {24'h0, pad_out[7:0]}, pad_out[0] ? 32'hFF : 32'h0);
        end
        chk("R5 toggle count", toggles, 4);
        chk("R5 input pin undriven", {31'h0, pad_oe[16]}, 32'h0);
        wr(5'h08, 32'h0);
        chk("R4 level restored", {24'h0, pad_out[7:0]}, 32'h5A);

        // R9 ignored writes and empty offsets
        wr(5'h10, 32'hDEAD_BEEF);
        wr(5'h14, 32'h0BAD_F00D);
        wr(5'h1C, 32'h1111_1111);
        rd(5'h00); chk("R9 level kept", bus_rdata, 32'hC3C3_5A5A);
        rd(5'h04); chk("R9 dir kept", bus_rdata, 32'hFFFF_0000);
        rd(5'h08); chk("R9 blink kept", bus_rdata, 32'h0);
        rd(5'h0C); chk("R9 invert kept", bus_rdata, 32'hFFFF_FFFF);
        rd(5'h14); chk("R9 empty offset", bus_rdata, 32'h0);
        rd(5'h1C); chk("R9 empty offset", bus_rdata, 32'h0);

        // R2 all outputs
        wr(5'h04, 32'h0);
        chk("R2 all outputs", pad_oe, 32'hFFFF_FFFF);
        rd(5'h10); chk("R7 all outputs", bus_rdata, 32'hC3C3_5A5A);
        step();

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule